// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line). It lets a bus master reach a bank of 8-bit registers that sit outside the block, through an internal pointer. Both bus lines are brought into the system clock domain through a short flip-flop chain. Every bus event is then found by edge detection on the system clock: a start, a stop, a clock rise or a clock fall. The block never runs on the bus clock itself.

A transaction opens with a start condition and an address frame. The frame is the 7-bit device address, most significant bit first, followed by a direction bit. In a write, the first byte after the address loads the pointer, and an optional second byte is written to the register the pointer names. In a read, one byte is returned from the register the pointer already names. The pointer never advances on its own. The register bank is reached through a plain port: address, write data, a one-cycle write strobe, and read data that may arrive one clock after the address, as from a block RAM.

Top module: `regbus_slave`

## Requirements
- R1: A frame of seven address bits equal to the configured device address (sent MSB first), followed by a direction bit (0 = write, 1 = read), is acknowledged: SDA is pulled low for the whole ninth clock high phase.
- R2: When the address frame does not match, SDA stays released for that frame and for every later bit, and no register is written, until the next start or stop.
- R3: In a write, the first byte after the address frame is acknowledged and becomes the pointer, which appears on `reg_addr`.
- R4: A second byte in the same write is acknowledged and produces exactly one `reg_we` pulse, lasting one clock, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R5: A write that carries only the pointer byte and then a stop changes the pointer and nothing else. No write strobe is issued.
- R6: A read returns, MSB first, the register selected by the pointer. The pointer does not advance after a read or a write, so repeated reads return the same register.
- R7: Once the eighth bit of a read byte is complete, SDA is released for the master's ninth bit. It stays released until the next start, whether the master acknowledged or not, so any further bytes the master clocks read as 0xFF.
- R8: Bytes after the second in a write are not acknowledged and cause no register write.
- R9: A start seen at any point, including a repeated start in the middle of a byte, restarts address reception.
- R10: The SDA drive enable changes only while the synchronised SCL is low.
- R11: After reset, SDA is released, `reg_we` is low and the pointer is zero.
- R12: A stop returns the block to idle. Bits clocked after a stop without a new start are neither acknowledged nor acted upon.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin (asynchronous) |
| sda_in | input | 1 | Bus data line as seen at the pin (asynchronous) |
| sda_oe | output | 1 | When high, the pad pulls SDA low. When low, SDA is released |
| reg_addr | output | REG_AW | Register address, equal to the pointer |
| reg_wdata | output | FRAME_W | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | FRAME_W | Register contents at `reg_addr`, valid one clock after the address |

## Verification
A pointer-plus-data write followed by a read separates a correct pointer load from a data byte that lands in the wrong place. A pointer-only write followed by two reads shows that the pointer neither writes a register nor advances. A wrong address, a third write byte, and bits clocked after a stop without a new start each expose a block that acknowledges or writes when it should stay silent. A repeated start after a full byte, and another in the middle of a byte, show that the bit count is reset. A read acknowledged by the master, followed by a second byte, confirms that SDA is released after one byte.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  // Protocol phases of the slave.
  typedef enum logic [3:0] {
    ST_IDLE,      // waiting for a start
    ST_ADDR,      // shifting in device address and direction bit
    ST_ADDR_ACK,  // driving acknowledge for the address frame
    ST_PTR,       // shifting in the pointer byte
    ST_PTR_ACK,   // driving acknowledge for the pointer byte
    ST_DATA,      // shifting in the register data byte
    ST_DATA_ACK,  // driving acknowledge for the data byte
    ST_READ,      // shifting out the selected register
    ST_SKIP       // silent until the next start or stop
  } bus_state_t;

endpackage

// File: rtl/twi_sync_bit.sv
module twi_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last;

  // Idle bus lines are high, so the chain resets to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~last;
  assign fall = ~lvl & last;

endmodule

// File: rtl/regbus_fsm.sv
module regbus_fsm
  import regbus_pkg::*;
#(
  parameter int                 FRAME_W  = 8,
  parameter int                 REG_AW   = 8,
  parameter logic [FRAME_W-2:0] DEV_ADDR = 'h4C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [FRAME_W-1:0] reg_rdata,
  output logic               sda_oe,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [FRAME_W-1:0] reg_wdata,
  output logic               reg_we
);

  localparam int            CW       = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_W);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  bus_state_t         state;
  logic [CW-1:0]      cnt;
  logic [FRAME_W-1:0] shreg;
  logic               rd_dir;
  logic [REG_AW-1:0]  ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      rd_dir    <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_DATA: begin
            if (scl_rise && cnt != CNT_FULL) begin
              shreg <= {shreg[FRAME_W-2:0], sda_lvl};
              cnt   <= cnt + CNT_ONE;
            end else if (scl_fall && cnt == CNT_FULL) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[FRAME_W-1:1] == DEV_ADDR) begin
                  rd_dir <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state  <= ST_SKIP;
                end
              end else if (state == ST_PTR) begin
                ptr    <= shreg[REG_AW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_PTR_ACK;
              end else begin
                reg_we    <= 1'b1;
                reg_wdata <= shreg;
                sda_oe    <= 1'b1;
                state     <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_dir) begin
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[FRAME_W-1];
                state  <= ST_READ;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_DATA;
            end
          end
          ST_DATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_SKIP;
            end
          end
          ST_READ: begin
            if (scl_rise && cnt != CNT_FULL) begin
              cnt <= cnt + CNT_ONE;
            end else if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end else begin
                sda_oe <= ~shreg[FRAME_W-2];
                shreg  <= {shreg[FRAME_W-2:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr = ptr;

  // R4: the write strobe is a single-cycle pulse
  a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R4: the pointer is steady while the register write is issued
  a_r4_ptr_steady: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $stable(reg_addr));

  // R2 / R7: the silent phase never drives the data line
  a_r2_skip_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_oe);

  // R6: a read never moves the pointer
  a_r6_no_autoinc: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ) |=> $stable(reg_addr));

endmodule

// File: rtl/regbus_slave.sv
module regbus_slave
  import regbus_pkg::*;
#(
  parameter int                 FRAME_W     = 8,
  parameter int                 REG_AW      = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [FRAME_W-2:0] DEV_ADDR    = 'h4C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [FRAME_W-1:0] reg_wdata,
  output logic               reg_we,
  input  logic [FRAME_W-1:0] reg_rdata
);

  localparam int N_LINES = 2;  // index 0: clock line, index 1: data line

  logic [N_LINES-1:0] raw, lvl, rise, fall;
  logic               start_det, stop_det;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    twi_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .lvl  (lvl[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  // Data line moving while the clock line stays high on both samples.
  assign start_det = fall[1] & lvl[0] & ~rise[0];
  assign stop_det  = rise[1] & lvl[0] & ~rise[0];

  regbus_fsm #(
    .FRAME_W  (FRAME_W),
    .REG_AW   (REG_AW),
    .DEV_ADDR (DEV_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_lvl   (lvl[1]),
    .scl_rise  (rise[0]),
    .scl_fall  (fall[0]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );

  // R10: the drive enable only moves while the clock line was low
  a_r10_low_phase: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(lvl[0]));

  // R9: a start is only ever seen with the data line released
  a_r9_start_released: assert property (@(posedge clk) disable iff (rst)
    start_det |-> !sda_oe);

  // R11: leaving reset, the bus and the strobe are quiet
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe && !reg_we));

endmodule

// File: tb/test_regbus_slave.sv
module test_regbus_slave;

  localparam int         H   = 8;        // system clocks per quarter bit
  localparam logic [6:0] DEV = 7'h4C;
  localparam logic [6:0] BAD = 7'h4D;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;

  int checks = 0;
  int fails  = 0;
  int r10_bad = 0;
  bit done = 1'b0;
  logic [15:0] wq[$];          // expected writes: {addr, data}
  logic [7:0]  mem [256];      // register bank stand-in

  always #10 clk = ~clk;       // 50 MHz

  assign sda_line = sda_m & ~sda_oe;

  regbus_slave i_regbus_slave (
    .clk (clk), .rst (rst), .scl_in (scl_m), .sda_in (sda_line),
    .sda_oe (sda_oe), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_we (reg_we), .reg_rdata (reg_rdata)
  );

  // Block-RAM-like register bank: one clock read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_we) mem[reg_addr] <= reg_wdata;
      reg_rdata <= mem[reg_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock model: every strobe must match the next expected write,
  // and the drive enable must never move while the master holds SCL high.
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) begin
        if (wq.size() == 0) chk(1'b0, "R5/R8/R2 unexpected write strobe", {reg_addr, reg_wdata}, 0);
        else begin
          logic [15:0] e;
          e = wq.pop_front();
          chk({reg_addr, reg_wdata} == e, "R4 write strobe contents", {reg_addr, reg_wdata}, e);
        end
      end
      if (sda_oe != prev_oe && scl_m) r10_bad++;
    end
    prev_oe = sda_oe;
  end

  task automatic hp(); repeat (H) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; hp(); scl_m = 1'b1; hp(); s = sda_line; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~m_ack, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic s;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    chk(reg_we == 1'b0, "R11 no strobe", reg_we, 0);
    chk(reg_addr == 8'h00, "R11 pointer zero", reg_addr, 0);
    hp();

    // R1 R3 R4: pointer plus data write
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R1 write address ack", ack, 1);
    send_byte(8'h10, ack);       chk(ack, "R3 pointer ack", ack, 1);
    wq.push_back({8'h10, 8'hA7});
    send_byte(8'hA7, ack);       chk(ack, "R4 data ack", ack, 1);
    bus_stop();
    chk(reg_addr == 8'h10, "R3 pointer on reg_addr", reg_addr, 8'h10);

    // R6: read back one byte
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R1 read address ack", ack, 1);
    recv_byte(1'b0, d);          chk(d == 8'hA7, "R6 read written value", d, 8'hA7);
    bus_stop();

    // R5: pointer-only write, then two reads (R6 no advance)
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h22, ack);       chk(ack, "R5 pointer-only ack", ack, 1);
    bus_stop();
    chk(reg_addr == 8'h22, "R5 pointer updated", reg_addr, 8'h22);
    for (int k = 0; k < 2; k++) begin
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      recv_byte(1'b0, d);
      chk(d == (8'h22 ^ 8'h5A), "R6 repeated read same register", d, 8'h22 ^ 8'h5A);
      bus_stop();
    end
    chk(reg_addr == 8'h22, "R6 pointer not advanced", reg_addr, 8'h22);

    // R2: address mismatch
    bus_start();
    send_byte({BAD, 1'b0}, ack); chk(!ack, "R2 mismatch not acked", ack, 0);
    send_byte(8'h33, ack);       chk(!ack, "R2 following byte not acked", ack, 0);
    send_byte(8'h44, ack);       chk(!ack, "R2 third byte not acked", ack, 0);
    bus_stop();
    chk(reg_addr == 8'h22, "R2 pointer untouched", reg_addr, 8'h22);

    // R8: extra write bytes
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h30, ack);
    wq.push_back({8'h30, 8'h11});
    send_byte(8'h11, ack);       chk(ack, "R4 second byte ack", ack, 1);
    send_byte(8'h99, ack);       chk(!ack, "R8 third byte not acked", ack, 0);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, d);          chk(d == 8'h11, "R8 extra byte discarded", d, 8'h11);
    bus_stop();

    // R9: repeated start after a full pointer byte
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h40, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R9 repeated start address ack", ack, 1);
    recv_byte(1'b0, d);          chk(d == (8'h40 ^ 8'h5A), "R9 read after repeated start", d, 8'h40 ^ 8'h5A);
    bus_stop();

    // R9: repeated start in the middle of a byte
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R9 mid-byte restart ack", ack, 1);
    recv_byte(1'b1, d);          chk(d == (8'h40 ^ 8'h5A), "R9 mid-byte restart data", d, 8'h40 ^ 8'h5A);
    // R7: master acknowledged, yet the next byte reads as released
    recv_byte(1'b0, d);          chk(d == 8'hFF, "R7 released after one byte", d, 8'hFF);
    bus_stop();
    chk(reg_addr == 8'h40, "R6 pointer after reads", reg_addr, 8'h40);

    // R12: stop aborts; bits without a new start are ignored
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    bus_stop();
    scl_m = 1'b0; hp();
    send_byte({DEV, 1'b0}, ack); chk(!ack, "R12 no ack without start", ack, 0);
    send_byte(8'h55, ack);       chk(!ack, "R12 byte after stop ignored", ack, 0);
    bus_stop();
    chk(reg_addr == 8'h40, "R12 pointer untouched", reg_addr, 8'h40);

    hp();
    chk(r10_bad == 0, "R10 drive changed with SCL high", r10_bad, 0);
    chk(wq.size() == 0, "R4 expected writes all seen", wq.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule